// File: doc/BRIEF.md
# Slot-Addressed Configuration Register Space

This block gives a board a bank of 512 byte-wide configuration registers. Software anywhere in the system reaches them through a 16-bit configuration address. The upper part of that address names a card slot and the lower part names a register. The block claims an access only when the slot field equals the board's own slot number, which arrives on an input pin. It also claims the access when the slot field holds the fixed local-host alias, 31. Accesses to any other slot are left to the other boards.

Two registers carry a hard-wired vendor identifier, and a third mirrors the live slot-number input. These three ignore writes without raising an error. The remaining registers are writable attribute bytes. A few of them load board type, revision and address-window bounds at reset, and the rest load zero.

Each access is a single-cycle request. A claimed access is acknowledged exactly one cycle later, and for a read the data comes back in the same cycle as the acknowledge.

Top module: `cfg_space`

## Requirements
- R1: While rst_ni is low and after it is released, ack_o is 0 and rdata_o is 0. After reset, register 2 reads BOARD_TYPE, register 3 reads REVISION, registers 5/6 read WIN_START low/high byte, registers 7/8 read WIN_END low/high byte, and every other writable register reads 0.
- R2: addr_i[8:0] selects register 0..511 and addr_i[13:9] selects the slot. Registers that differ only in bit 8 of the address are distinct.
- R3: A claimed read issued with req_i high in cycle n gives ack_o high in cycle n+1 for exactly one cycle, with rdata_o holding the register value in that same cycle.
- R4: A claimed write issued in cycle n gives ack_o high in cycle n+1. A read of a writable register returns the last byte written to it.
- R5: Register 0 reads VENDOR_ID[7:0] and register 1 reads VENDOR_ID[15:8]. Writes to either are acknowledged and have no effect.
- R6: Register 4 reads {3'b000, slot_i} as sampled at the request. Writes to it are acknowledged and have no effect.
- R7: An access whose slot field is 31 is claimed regardless of slot_i.
- R8: An access whose slot field is neither slot_i nor 31 is not acknowledged and changes no register.
- R9: An access with addr_i[15:14] not equal to 0 is not acknowledged and changes no register.
- R10: rdata_o is 0 in every cycle that is not a read acknowledge, including write acknowledges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| slot_i | input | 5 | This board's card-slot number |
| req_i | input | 1 | Access request, one cycle per access |
| we_i | input | 1 | 1 for write, 0 for read |
| addr_i | input | 16 | Configuration address: pad, slot, register |
| wdata_i | input | 8 | Write byte |
| ack_o | output | 1 | Acknowledge, one cycle after a claimed request |
| rdata_o | output | 8 | Read byte, valid with a read acknowledge |

## Verification
Every result of this block is due exactly one clock after the request: the acknowledge, the read byte and the zero data on a write. A register change made by a write becomes visible to a read issued in the following cycle.

The bench drives each request on a falling edge and samples ack_o and rdata_o on the next falling edge. That edge falls half a period after the single capturing rising edge. Unclaimed accesses are checked the same way for a missing acknowledge, and then through a later claimed read of the same register.

// File: rtl/cfg_space_pkg.sv
package cfg_space_pkg;

  localparam int unsigned DATA_W = 8;

  typedef logic [DATA_W-1:0] byte_t;

  // Reset image of a writable attribute register
  function automatic byte_t attr_reset(input int unsigned idx,
                                       input logic [7:0]  board_type,
                                       input logic [7:0]  revision,
                                       input logic [15:0] win_start,
                                       input logic [15:0] win_end);
    case (idx)
      2:       return board_type;
      3:       return revision;
      5:       return win_start[7:0];
      6:       return win_start[15:8];
      7:       return win_end[7:0];
      8:       return win_end[15:8];
      default: return '0;
    endcase
  endfunction

endpackage

// File: rtl/cfg_addr_decode.sv
module cfg_addr_decode #(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned SLOT_W    = 5,
  parameter int unsigned IDX_W     = 9,
  parameter int unsigned HOST_SLOT = 31
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [SLOT_W-1:0] slot_i,
  output logic              claim_o,
  output logic [IDX_W-1:0]  idx_o
);
  localparam int unsigned PAD_W = ADDR_W - SLOT_W - IDX_W;

  logic [PAD_W-1:0]  pad;
  logic [SLOT_W-1:0] slot_f;

  assign idx_o  = addr_i[IDX_W-1:0];
  assign slot_f = addr_i[IDX_W +: SLOT_W];
  assign pad    = addr_i[ADDR_W-1 -: PAD_W];

  always_comb begin
    claim_o = 1'b0;
    if (pad == '0) begin
      claim_o = (slot_f == slot_i) || (slot_f == SLOT_W'(HOST_SLOT));
    end
  end
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
  import cfg_space_pkg::*;
#(
  parameter int unsigned REG_COUNT  = 512,
  parameter int unsigned IDX_W      = 9,
  parameter int unsigned SLOT_W     = 5,
  parameter int unsigned SLOT_REG   = 4,
  parameter logic [15:0] VENDOR_ID  = 16'hA51C,
  parameter logic [7:0]  BOARD_TYPE = 8'h03,
  parameter logic [7:0]  REVISION   = 8'h12,
  parameter logic [15:0] WIN_START  = 16'h0040,
  parameter logic [15:0] WIN_END    = 16'h00FF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  byte_t             wdata_i,
  input  logic [SLOT_W-1:0] slot_i,
  output byte_t             rdata_o
);
  byte_t view [REG_COUNT];

  for (genvar g = 0; g < REG_COUNT; g++) begin : g_reg
    if (g < 2) begin : g_vendor
      assign view[g] = VENDOR_ID[8*g +: 8];
    end else if (g == SLOT_REG) begin : g_slot
      assign view[g] = byte_t'(slot_i);
    end else begin : g_rw
      localparam byte_t RST_VAL =
        attr_reset(g, BOARD_TYPE, REVISION, WIN_START, WIN_END);
      byte_t q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          q <= RST_VAL;
        end else if (wr_en_i && idx_i == IDX_W'(g)) begin
          q <= wdata_i;
        end
      end
      assign view[g] = q;
    end
  end

  assign rdata_o = view[idx_i];
endmodule

// File: rtl/cfg_space.sv
module cfg_space
  import cfg_space_pkg::*;
#(
  parameter int unsigned REG_COUNT  = 512,
  parameter int unsigned SLOT_W     = 5,
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned HOST_SLOT  = 31,
  parameter int unsigned SLOT_REG   = 4,
  parameter logic [15:0] VENDOR_ID  = 16'hA51C,
  parameter logic [7:0]  BOARD_TYPE = 8'h03,
  parameter logic [7:0]  REVISION   = 8'h12,
  parameter logic [15:0] WIN_START  = 16'h0040,
  parameter logic [15:0] WIN_END    = 16'h00FF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic              ack_o,
  output logic [7:0]        rdata_o
);
  localparam int unsigned IDX_W = $clog2(REG_COUNT);

  logic             claim;
  logic [IDX_W-1:0] idx;
  byte_t            bank_rdata;
  logic             hit;

  cfg_addr_decode #(
    .ADDR_W   (ADDR_W),
    .SLOT_W   (SLOT_W),
    .IDX_W    (IDX_W),
    .HOST_SLOT(HOST_SLOT)
  ) u_dec (
    .addr_i (addr_i),
    .slot_i (slot_i),
    .claim_o(claim),
    .idx_o  (idx)
  );

  assign hit = req_i && claim;

  cfg_reg_bank #(
    .REG_COUNT (REG_COUNT),
    .IDX_W     (IDX_W),
    .SLOT_W    (SLOT_W),
    .SLOT_REG  (SLOT_REG),
    .VENDOR_ID (VENDOR_ID),
    .BOARD_TYPE(BOARD_TYPE),
    .REVISION  (REVISION),
    .WIN_START (WIN_START),
    .WIN_END   (WIN_END)
  ) u_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_en_i(hit && we_i),
    .idx_i  (idx),
    .wdata_i(wdata_i),
    .slot_i (slot_i),
    .rdata_o(bank_rdata)
  );

  // Response stage: acknowledge and read data one cycle after request
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_o   <= 1'b0;
      rdata_o <= '0;
    end else begin
      ack_o   <= hit;
      rdata_o <= (hit && !we_i) ? bank_rdata : '0;
    end
  end
endmodule

// File: rtl/cfg_space_chk.sv
module cfg_space_chk #(
  parameter int unsigned SLOT_W    = 5,
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned HOST_SLOT = 31,
  parameter int unsigned SLOT_REG  = 4,
  parameter logic [15:0] VENDOR_ID = 16'hA51C
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [SLOT_W-1:0] slot_i,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              ack_o,
  input logic [7:0]        rdata_o
);
  logic [SLOT_W-1:0] a_slot;
  logic              mine;
  logic              rd_reg0, rd_reg1, rd_slot;

  assign a_slot  = addr_i[9 +: SLOT_W];
  assign mine    = (addr_i[ADDR_W-1:14] == '0) &&
                   ((a_slot == slot_i) || (a_slot == SLOT_W'(HOST_SLOT)));
  assign rd_reg0 = req_i && !we_i && mine && addr_i[8:0] == 9'd0;
  assign rd_reg1 = req_i && !we_i && mine && addr_i[8:0] == 9'd1;
  assign rd_slot = req_i && !we_i && mine && addr_i[8:0] == 9'(SLOT_REG);

  p_ack_claimed_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && mine) |=> ack_o);
  p_no_ack_foreign_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && mine) |=> !ack_o);
  p_vendor_lo_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_reg0 |=> rdata_o == VENDOR_ID[7:0]);
  p_vendor_hi_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_reg1 |=> rdata_o == VENDOR_ID[15:8]);
  p_slot_mirror_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_slot |=> rdata_o == 8'($past(slot_i)));
  p_write_zero_data_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i) |=> rdata_o == '0);
  p_idle_zero_data_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_o |-> rdata_o == '0);
endmodule

bind cfg_space cfg_space_chk #(
  .SLOT_W   (SLOT_W),
  .ADDR_W   (ADDR_W),
  .HOST_SLOT(HOST_SLOT),
  .SLOT_REG (SLOT_REG),
  .VENDOR_ID(VENDOR_ID)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .slot_i (slot_i),
  .req_i  (req_i),
  .we_i   (we_i),
  .addr_i (addr_i),
  .ack_o  (ack_o),
  .rdata_o(rdata_o)
);

// File: tb/cfg_space_tb.sv
module cfg_space_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [4:0]  slot_i = 5'd7;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [15:0] addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic        ack_o;
  logic [7:0]  rdata_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk_i = ~clk_i;

  cfg_space u_dut (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .slot_i (slot_i),
    .req_i  (req_i),
    .we_i   (we_i),
    .addr_i (addr_i),
    .wdata_i(wdata_i),
    .ack_o  (ack_o),
    .rdata_o(rdata_o)
  );

  typedef struct packed {
    logic        req;
    logic        we;
    logic [15:0] addr;
    logic [7:0]  wd;
    logic        ack;
    logic [7:0]  rd;
    logic [7:0]  tag;
  } vec_t;

  localparam int NV = 30;
  // own slot 7 -> slot field 0x0E00; alias 31 -> 0x3E00; foreign slot 8 -> 0x1000
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 16'h0E00, 8'h00, 1'b1, 8'h1C, 8'd5},  // R5 vendor low
    '{1'b1, 1'b0, 16'h0E01, 8'h00, 1'b1, 8'hA5, 8'd5},  // R5 vendor high
    '{1'b1, 1'b1, 16'h0E00, 8'hFF, 1'b1, 8'h00, 8'd5},  // R5 discarded write
    '{1'b1, 1'b1, 16'h0E01, 8'h00, 1'b1, 8'h00, 8'd10}, // R10 write ack data 0
    '{1'b1, 1'b0, 16'h0E00, 8'h00, 1'b1, 8'h1C, 8'd5},  // R5 unchanged
    '{1'b1, 1'b0, 16'h0E01, 8'h00, 1'b1, 8'hA5, 8'd5},  // R5 unchanged
    '{1'b1, 1'b0, 16'h0E02, 8'h00, 1'b1, 8'h03, 8'd1},  // R1 board type
    '{1'b1, 1'b0, 16'h0E03, 8'h00, 1'b1, 8'h12, 8'd1},  // R1 revision
    '{1'b1, 1'b0, 16'h0E05, 8'h00, 1'b1, 8'h40, 8'd1},  // R1 window start lo
    '{1'b1, 1'b0, 16'h0E07, 8'h00, 1'b1, 8'hFF, 8'd1},  // R1 window end lo
    '{1'b1, 1'b0, 16'h0E09, 8'h00, 1'b1, 8'h00, 8'd1},  // R1 plain attr zero
    '{1'b1, 1'b1, 16'h0E02, 8'h5A, 1'b1, 8'h00, 8'd4},  // R4 write
    '{1'b1, 1'b0, 16'h0E02, 8'h00, 1'b1, 8'h5A, 8'd4},  // R4 readback
    '{1'b1, 1'b1, 16'h3FFF, 8'h77, 1'b1, 8'h00, 8'd7},  // R7 alias write reg 511
    '{1'b1, 1'b0, 16'h0FFF, 8'h00, 1'b1, 8'h77, 8'd7},  // R7 own-slot readback
    '{1'b1, 1'b1, 16'h1002, 8'h99, 1'b0, 8'h00, 8'd8},  // R8 foreign write
    '{1'b1, 1'b0, 16'h0E02, 8'h00, 1'b1, 8'h5A, 8'd8},  // R8 no change
    '{1'b1, 1'b0, 16'h1002, 8'h00, 1'b0, 8'h00, 8'd8},  // R8 foreign read
    '{1'b1, 1'b1, 16'h4E02, 8'h11, 1'b0, 8'h00, 8'd9},  // R9 pad bit 14
    '{1'b1, 1'b0, 16'h8E02, 8'h00, 1'b0, 8'h00, 8'd9},  // R9 pad bit 15
    '{1'b1, 1'b0, 16'h0E02, 8'h00, 1'b1, 8'h5A, 8'd9},  // R9 no change
    '{1'b1, 1'b0, 16'h0E04, 8'h00, 1'b1, 8'h07, 8'd6},  // R6 slot mirror
    '{1'b1, 1'b1, 16'h0E04, 8'h1F, 1'b1, 8'h00, 8'd6},  // R6 discarded write
    '{1'b1, 1'b0, 16'h0E04, 8'h00, 1'b1, 8'h07, 8'd6},  // R6 unchanged
    '{1'b0, 1'b0, 16'h0E02, 8'h00, 1'b0, 8'h00, 8'd10}, // R10 idle
    '{1'b1, 1'b1, 16'h3F2C, 8'hC3, 1'b1, 8'h00, 8'd2},  // R2 reg 300 via alias
    '{1'b1, 1'b0, 16'h0F2C, 8'h00, 1'b1, 8'hC3, 8'd2},  // R2 reg 300 readback
    '{1'b1, 1'b1, 16'h0F00, 8'h44, 1'b1, 8'h00, 8'd2},  // R2 reg 256
    '{1'b1, 1'b0, 16'h0E00, 8'h00, 1'b1, 8'h1C, 8'd2},  // R2 reg 0 distinct
    '{1'b1, 1'b0, 16'h0F00, 8'h00, 1'b1, 8'h44, 8'd3}   // R3 read timing
  };

  task automatic check(input string name, input logic [8:0] act,
                       input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", name, act, exp);
    end
  endtask

  // Drive on falling edge, sample one period later (one register stage)
  task automatic access(input logic rq, input logic w, input logic [15:0] a,
                        input logic [7:0] d, input logic eack,
                        input logic [7:0] erd, input string name);
    @(negedge clk_i);
    req_i = rq; we_i = w; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0;
    check(name, {ack_o, rdata_o}, {eack, erd});
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1 reset outputs", {ack_o, rdata_o}, 9'h000);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 after release", {ack_o, rdata_o}, 9'h000);

    for (int i = 0; i < NV; i++) begin
      access(VECS[i].req, VECS[i].we, VECS[i].addr, VECS[i].wd,
             VECS[i].ack, VECS[i].rd, $sformatf("R%0d vec %0d", VECS[i].tag, i));
    end

    // R3: back-to-back reads, each acknowledged one cycle later
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b0; addr_i = 16'h0E03;
    @(negedge clk_i);
    check("R3 first of pair", {ack_o, rdata_o}, {1'b1, 8'h12});
    addr_i = 16'h0E05;
    @(negedge clk_i);
    req_i = 1'b0;
    check("R3 second of pair", {ack_o, rdata_o}, {1'b1, 8'h40});
    @(negedge clk_i);
    check("R3 single pulse", {ack_o, rdata_o}, 9'h000);

    // R6: mirror follows slot_i; R8: old slot no longer claimed
    slot_i = 5'd12;
    access(1'b1, 1'b0, 16'h3E04, 8'h00, 1'b1, 8'h0C, "R6 new slot via alias");
    access(1'b1, 1'b0, 16'h0E02, 8'h00, 1'b0, 8'h00, "R8 old slot unclaimed");
    access(1'b1, 1'b0, 16'h1802, 8'h00, 1'b1, 8'h5A, "R4 new own slot");

    // R1: reset restores attribute values
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    check("R1 in reset", {ack_o, rdata_o}, 9'h000);
    rst_ni = 1'b1;
    access(1'b1, 1'b0, 16'h1802, 8'h00, 1'b1, 8'h03, "R1 reg2 restored");
    access(1'b1, 1'b0, 16'h19FF, 8'h00, 1'b1, 8'h00, "R1 reg511 restored");
    access(1'b1, 1'b0, 16'h1808, 8'h00, 1'b1, 8'h00, "R1 window end hi");

    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000; c++) begin
      @(posedge clk_i);
      if (done) break;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule